// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a stereo serial audio stream into parallel words. It is clocked by the incoming bit clock itself and watches a frame clock that marks left/right halves and a serial data line that carries two's-complement samples, most significant bit first, left word before right word. Four framings are understood: right-justified, I2S, left-justified and a pulse-framed DSP style. Word lengths of 16, 18, 20 and 24 bits are accepted.

The framing is chosen by a 2-bit format code. It can come from strap pins or from a register field. The code in use is the bitwise OR of both, so the source that is not in use must be held at zero. Each received word is sign-extended to 24 bits. A one-cycle strobe marks the cycle in which a fresh left/right pair is on the outputs. The 32-bit-clock-per-frame packed case needs no extra setting in the justified formats.

Top module: `audio_serial_rx`

## Requirements
- R1: The active format is `fmt_pins | fmt_reg`. Code 00 selects right-justified, 01 selects I2S, 10 selects left-justified and 11 selects DSP framing.
- R2: `wlen_sel` sets the word length: 00 is 16 bits, 01 is 18, 10 is 20 and 11 is 24. In right-justified format the length is always 16, whatever `wlen_sel` holds.
- R3: Left-justified: frame clock high marks the left half. The MSB is the bit sampled on the first rising bit-clock edge that sees the new frame-clock level.
- R4: I2S: frame clock low marks the left half. The MSB is sampled one bit clock after the first sample that sees the new level. Sampling is on the rising edge.
- R5: Right-justified: the word is the 16 bits sampled on rising edges just before the frame-clock change. This works for both 64 and 32 bit clocks per frame.
- R6: DSP: data and frame clock are sampled on the falling bit-clock edge. A high frame-clock pulse starts each half, and the MSB is the bit after the sample that first sees the pulse high. The first pulse after reset starts a left word, and the channels alternate from then on.
- R7: Slots after the last bit of the selected word length are ignored. If a half ends before all bits have arrived, the missing low bits read as zero.
- R8: Each output holds the received N-bit word sign-extended to 24 bits, with bits 23 down to N-1 equal.
- R9: `pair_valid` is high for exactly one cycle. It rises at the frame boundary that ends a right half, with `left_word` and `right_word` both updated for that pair. `right_word` never changes while `pair_valid` is low.
- R10: Reset is synchronous and active high. It clears both words and `pair_valid`. The first frame boundary after reset only starts a half, so the first strobe follows the first complete left and right words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; the block's only clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_pins | input | 2 | Format code from strap pins |
| fmt_reg | input | 2 | Format code from a register field |
| wlen_sel | input | 2 | Word length code |
| lrck | input | 1 | Frame clock (left/right or frame pulse) |
| sdata | input | 1 | Serial data, MSB first |
| left_word | output | 24 | Sign-extended left sample |
| right_word | output | 24 | Sign-extended right sample |
| pair_valid | output | 1 | One-cycle strobe for a new pair |

## Verification
The one sample that sees a frame-clock change does two jobs at once. It closes the finished word, committing it to an output and perhaps raising the strobe. In left-justified format it also supplies the MSB of the next word. The bench provokes this with back-to-back frames in every format and in the packed 32-clock frames, where every slot of a half carries data. It then compares each recovered pair bit for bit with the words that were sent, sign-extended from the selected length. Junk ones sent after the last data bit show whether the start of the next word stayed clean.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

    localparam int POS_W  = 6;
    localparam int RJ_LEN = 16;

    typedef enum logic [1:0] {
        FMT_RJ  = 2'b00,
        FMT_I2S = 2'b01,
        FMT_LJ  = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    typedef struct packed {
        logic lr;
        logic d;
    } samp_t;

    typedef struct packed {
        logic             bound;
        logic             commit;
        logic             commit_left;
        logic             take;
        logic [POS_W-1:0] pos;
        logic             d;
    } ev_t;

    function automatic fmt_e fmt_merge(input logic [1:0] a, input logic [1:0] b);
        return fmt_e'(a | b);
    endfunction

    function automatic logic [POS_W-1:0] wlen_bits(input logic [1:0] code, input fmt_e fmt);
        logic [POS_W-1:0] n;
        if (fmt == FMT_RJ) begin
            n = POS_W'(RJ_LEN);
        end else begin
            case (code)
                2'b00:   n = POS_W'(16);
                2'b01:   n = POS_W'(18);
                2'b10:   n = POS_W'(20);
                default: n = POS_W'(24);
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/arx_sampler.sv
module arx_sampler
    import audio_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fmt_e  fmt,
    input  logic  lr_in,
    input  logic  sd_in,
    output samp_t smp
);

    samp_t fall_q;

    // falling-edge capture used only by the pulse-framed format
    always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= samp_t'({lr_in, sd_in});
    end

    always_comb begin
        if (fmt == FMT_DSP) smp = fall_q;
        else                smp = samp_t'({lr_in, sd_in});
    end

endmodule

// File: rtl/arx_framer.sv
module arx_framer
    import audio_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fmt_e       fmt,
    input  logic [1:0] wlen_code,
    input  samp_t      smp,
    output ev_t        ev
);

    logic             primed_q;
    logic             armed_q;
    logic             prev_lr_q;
    logic             cur_left_q;
    logic [POS_W-1:0] idx_q;

    logic             edge_hit;
    logic             next_left;
    logic [POS_W-1:0] idx;
    logic [POS_W-1:0] offset;
    logic [POS_W-1:0] nbits;
    logic             in_half;

    always_comb begin
        if (fmt == FMT_DSP) edge_hit = primed_q && smp.lr && !prev_lr_q;
        else                edge_hit = primed_q && (smp.lr != prev_lr_q);

        case (fmt)
            FMT_I2S: next_left = !smp.lr;
            FMT_DSP: next_left = armed_q ? !cur_left_q : 1'b1;
            default: next_left = smp.lr;
        endcase

        if (edge_hit)          idx = '0;
        else if (idx_q == '1)  idx = idx_q;
        else                   idx = idx_q + 1'b1;

        offset  = (fmt == FMT_I2S || fmt == FMT_DSP) ? POS_W'(1) : POS_W'(0);
        nbits   = wlen_bits(wlen_code, fmt);
        in_half = armed_q || edge_hit;

        ev.bound       = edge_hit;
        ev.commit      = edge_hit && armed_q;
        ev.commit_left = cur_left_q;
        ev.pos         = idx - offset;
        ev.take        = in_half && (idx >= offset) && ((idx - offset) < nbits);
        ev.d           = smp.d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            primed_q   <= 1'b0;
            armed_q    <= 1'b0;
            prev_lr_q  <= 1'b0;
            cur_left_q <= 1'b0;
            idx_q      <= '0;
        end else begin
            primed_q  <= 1'b1;
            prev_lr_q <= smp.lr;
            idx_q     <= idx;
            if (edge_hit) begin
                armed_q    <= 1'b1;
                cur_left_q <= next_left;
            end
        end
    end

endmodule

// File: rtl/arx_assembler.sv
module arx_assembler
    import audio_rx_pkg::*;
#(
    parameter int OUT_W = 24,
    parameter int RJ_W  = RJ_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  fmt_e             fmt,
    input  logic [1:0]       wlen_code,
    input  ev_t              ev,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             valid_o
);

    localparam int PAD_W = OUT_W - RJ_W;

    logic [OUT_W-1:0]        acc_q;
    logic [OUT_W-1:0]        acc_n;
    logic [RJ_W-1:0]         sh_q;
    logic signed [OUT_W-1:0] acc_s;
    logic [OUT_W-1:0]        word;
    logic [POS_W-1:0]        nb;
    int                      shamt;

    always_comb begin
        acc_n = ev.bound ? '0 : acc_q;
        for (int b = 0; b < OUT_W; b++) begin
            if (ev.take && ev.pos == POS_W'(OUT_W - 1 - b)) acc_n[b] = ev.d;
        end
    end

    always_comb begin
        nb    = wlen_bits(wlen_code, fmt);
        shamt = OUT_W - int'(nb);
        acc_s = acc_q;
        if (fmt == FMT_RJ) word = {{PAD_W{sh_q[RJ_W-1]}}, sh_q};
        else               word = OUT_W'(acc_s >>> shamt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            sh_q    <= '0;
            left_o  <= '0;
            right_o <= '0;
            valid_o <= 1'b0;
        end else begin
            acc_q   <= acc_n;
            sh_q    <= {sh_q[RJ_W-2:0], ev.d};
            valid_o <= 1'b0;
            if (ev.commit) begin
                if (ev.commit_left) begin
                    left_o <= word;
                end else begin
                    right_o <= word;
                    valid_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import audio_rx_pkg::*;
#(
    parameter int OUT_W = 24,
    parameter int RJ_W  = RJ_LEN
) (
    input  logic             bclk,
    input  logic             rst,
    input  logic [1:0]       fmt_pins,
    input  logic [1:0]       fmt_reg,
    input  logic [1:0]       wlen_sel,
    input  logic             lrck,
    input  logic             sdata,
    output logic [OUT_W-1:0] left_word,
    output logic [OUT_W-1:0] right_word,
    output logic             pair_valid
);

    fmt_e  fmt;
    samp_t smp;
    ev_t   ev;

    assign fmt = fmt_merge(fmt_pins, fmt_reg);

    arx_sampler u_smp (
        .clk   (bclk),
        .rst   (rst),
        .fmt   (fmt),
        .lr_in (lrck),
        .sd_in (sdata),
        .smp   (smp)
    );

    arx_framer u_frm (
        .clk       (bclk),
        .rst       (rst),
        .fmt       (fmt),
        .wlen_code (wlen_sel),
        .smp       (smp),
        .ev        (ev)
    );

    arx_assembler #(
        .OUT_W (OUT_W),
        .RJ_W  (RJ_W)
    ) u_asm (
        .clk       (bclk),
        .rst       (rst),
        .fmt       (fmt),
        .wlen_code (wlen_sel),
        .ev        (ev),
        .left_o    (left_word),
        .right_o   (right_word),
        .valid_o   (pair_valid)
    );

endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk
    import audio_rx_pkg::*;
#(
    parameter int OUT_W = 24
) (
    input logic             bclk,
    input logic             rst,
    input logic [1:0]       fmt_pins,
    input logic [1:0]       fmt_reg,
    input logic [1:0]       wlen_sel,
    input logic [OUT_W-1:0] left_word,
    input logic [OUT_W-1:0] right_word,
    input logic             pair_valid
);

    logic [POS_W-1:0] nb_q;
    logic             ext_ok;

    always_ff @(posedge bclk) begin
        if (rst) nb_q <= POS_W'(RJ_LEN);
        else     nb_q <= wlen_bits(wlen_sel, fmt_merge(fmt_pins, fmt_reg));
    end

    always_comb begin
        ext_ok = 1'b1;
        for (int b = 0; b < OUT_W; b++) begin
            if (b >= int'(nb_q) - 1 && right_word[b] != right_word[OUT_W-1]) ext_ok = 1'b0;
        end
    end

    assert_strobe_single_R9: assert property (@(posedge bclk) disable iff (rst)
        pair_valid |=> !pair_valid);

    assert_right_hold_R9: assert property (@(posedge bclk) disable iff (rst)
        !pair_valid |-> $stable(right_word));

    assert_sign_extend_R8: assert property (@(posedge bclk) disable iff (rst)
        pair_valid |-> ext_ok);

    assert_reset_clear_R10: assert property (@(posedge bclk)
        rst |=> (!pair_valid && left_word == '0 && right_word == '0));

endmodule

bind audio_serial_rx audio_serial_rx_chk #(.OUT_W(OUT_W)) u_chk (
    .bclk       (bclk),
    .rst        (rst),
    .fmt_pins   (fmt_pins),
    .fmt_reg    (fmt_reg),
    .wlen_sel   (wlen_sel),
    .left_word  (left_word),
    .right_word (right_word),
    .pair_valid (pair_valid)
);

// File: tb/sim_audio_serial_rx.sv
module sim_audio_serial_rx;

    localparam int CLK_PERIOD = 10;
    localparam int FMT_RJ  = 0;
    localparam int FMT_I2S = 1;
    localparam int FMT_LJ  = 2;
    localparam int FMT_DSP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt_pins = 2'b00;
    logic [1:0]  fmt_reg = 2'b00;
    logic [1:0]  wlen_sel = 2'b00;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic [23:0] left_word;
    logic [23:0] right_word;
    logic        pair_valid;

    int total = 0;
    int bad = 0;
    int nv = 0;
    logic [23:0] got_l [0:7];
    logic [23:0] got_r [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_serial_rx u0 (
        .bclk       (clk),
        .rst        (rst),
        .fmt_pins   (fmt_pins),
        .fmt_reg    (fmt_reg),
        .wlen_sel   (wlen_sel),
        .lrck       (lrck),
        .sdata      (sdata),
        .left_word  (left_word),
        .right_word (right_word),
        .pair_valid (pair_valid)
    );

    // capture strobed pairs half a cycle after the edge that raised the strobe
    always @(negedge clk) begin
        if (rst) begin
            nv = 0;
        end else if (pair_valid) begin
            if (nv < 8) begin
                got_l[nv] = left_word;
                got_r[nv] = right_word;
            end
            nv = nv + 1;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input logic ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] word_of(input int cfg, input int f, input int ch);
        logic [23:0] v;
        v = 24'(cfg * 32'h1F0F1 + f * 32'h3A5C9 + ch * 32'h6D2B7 + 32'h800123);
        if (f % 2 == 1) v = v ^ 24'h800000;
        return v;
    endfunction

    function automatic logic [23:0] expect_word(input logic [23:0] w, input int n_eff, input int recv);
        int k;
        logic [23:0] m;
        logic signed [23:0] s;
        k = (n_eff < recv) ? n_eff : recv;
        m = w & ~((24'h1 << (24 - k)) - 24'h1);
        s = m;
        return 24'(s >>> (24 - n_eff));
    endfunction

    task automatic drive_slot(input logic lr, input logic d, input bit dsp);
        if (dsp) begin
            @(posedge clk);
            #2;
        end else begin
            @(negedge clk);
            #1;
        end
        lrck  = lr;
        sdata = d;
    endtask

    task automatic send_half(input int fm, input logic left, input logic [23:0] w, input int n, input int hl);
        for (int s = 0; s < hl; s++) begin
            logic lr;
            logic b;
            int   i;
            b = 1'b1;
            case (fm)
                FMT_RJ: begin
                    lr = left;
                    i = s - (hl - 16);
                    if (i >= 0) b = w[23 - i];
                end
                FMT_LJ: begin
                    lr = left;
                    if (s < n) b = w[23 - s];
                end
                FMT_I2S: begin
                    lr = !left;
                    i = s - 1;
                    if (i >= 0 && i < n) b = w[23 - i];
                end
                default: begin
                    lr = (s == 0);
                    i = s - 1;
                    if (i >= 0 && i < n) b = w[23 - i];
                end
            endcase
            drive_slot(lr, b, fm == FMT_DSP);
        end
    endtask

    task automatic run_cfg(input int fm, input int wl, input bit split, input int hl, input int nfr, input int cfg);
        int    n_eff;
        int    recv;
        string ftag;
        bit    dsp;
        dsp = (fm == FMT_DSP);
        case (fm)
            FMT_RJ:  ftag = "R5";
            FMT_I2S: ftag = "R4";
            FMT_LJ:  ftag = "R3";
            default: ftag = "R6";
        endcase
        if (split) begin
            fmt_pins = 2'(fm) & 2'b10;
            fmt_reg  = 2'(fm) & 2'b01;
            ftag = {ftag, " R1"};
        end else begin
            fmt_pins = 2'(fm);
            fmt_reg  = 2'b00;
        end
        wlen_sel = 2'(wl);
        n_eff = (fm == FMT_RJ) ? 16 : (wl == 0 ? 16 : wl == 1 ? 18 : wl == 2 ? 20 : 24);
        case (fm)
            FMT_RJ:  recv = 16;
            FMT_LJ:  recv = hl;
            default: recv = hl - 1;
        endcase

        @(posedge clk);
        #2;
        rst = 1'b1;
        sdata = 1'b0;
        lrck = (fm == FMT_I2S) ? 1'b1 : 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset clears outputs and strobe
        check(pair_valid == 1'b0, "R10 strobe in reset", 24'(pair_valid), 24'h0);
        check(left_word == 24'h0 && right_word == 24'h0, "R10 words in reset", left_word | right_word, 24'h0);
        @(posedge clk);
        #2;
        rst = 1'b0;

        if (dsp) begin
            for (int s = 0; s < 4; s++) drive_slot(1'b0, 1'b0, 1'b1);
        end else begin
            send_half(fm, 1'b0, 24'h0, n_eff, hl);
        end
        for (int f = 0; f < nfr; f++) begin
            send_half(fm, 1'b1, word_of(cfg, f, 0), n_eff, hl);
            send_half(fm, 1'b0, word_of(cfg, f, 1), n_eff, hl);
        end
        send_half(fm, 1'b1, 24'h0, n_eff, hl);
        repeat (2) @(negedge clk);

        // R9 and R10: one strobe per complete pair, none for the start-up half
        check(nv == nfr, $sformatf("R9 R10 pair count cfg %0d", cfg), 24'(nv), 24'(nfr));
        for (int f = 0; f < nfr && f < 8; f++) begin
            logic [23:0] el;
            logic [23:0] er;
            el = expect_word(word_of(cfg, f, 0), n_eff, recv);
            er = expect_word(word_of(cfg, f, 1), n_eff, recv);
            check(got_l[f] == el, $sformatf("%s R2 R7 R8 left cfg %0d frame %0d", ftag, cfg, f), got_l[f], el);
            check(got_r[f] == er, $sformatf("%s R2 R7 R8 right cfg %0d frame %0d", ftag, cfg, f), got_r[f], er);
        end
    endtask

    initial begin
        int cfg;
        cfg = 0;
        for (int fm = 0; fm < 4; fm++) begin
            for (int wl = 0; wl < 4; wl++) begin
                run_cfg(fm, wl, ((fm + wl) % 2) == 1, 32, 3, cfg);
                cfg = cfg + 1;
            end
        end
        // packed frames of 32 bit clocks: R3 and R5
        run_cfg(FMT_LJ, 0, 1'b0, 16, 3, cfg);
        cfg = cfg + 1;
        run_cfg(FMT_RJ, 2, 1'b1, 16, 3, cfg);
        cfg = cfg + 1;
        // R7: 24-bit length but only 16 slots per half, low bits read as zero
        run_cfg(FMT_LJ, 3, 1'b0, 16, 2, cfg);
        cfg = cfg + 1;
        // R7: I2S 24-bit word in a short half loses its tail
        run_cfg(FMT_I2S, 3, 1'b1, 20, 2, cfg);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule